// File: doc/BRIEF.md
# Interleaved Wide-Word DDR Output Gearbox

The gearbox takes one 512-bit word on every rising edge of a slow clock. It spreads that word over 64 output lanes that run at double data rate on a fast clock. The fast clock runs at four times the slow rate, and the block also receives the fast clock's inverted copy. The lanes form 16 groups of four. Group `m` owns every sixteenth input bit, starting at bit `m`. Inside a group, the four lanes carry consecutive group bits on each clock edge. An external 4:1 multiplexer per group, followed by a 16:1 bit interleave across the groups, therefore rebuilds the input word in its original serial order.

Each fast cycle carries one slice of the word. The rising-edge half of the slice leaves on the fast clock's rising edge. The falling-edge half leaves half a period later, on the rising edge of the inverted clock. A phase counter in the fast domain restarts at every new slow word, so all 16 groups step through the four slices in lock-step. Two enables act separately: one forces the data lanes low, and the other holds the forwarded copy of the fast clock low.

Top module: `ddr_lane_gearbox`

## Requirements
- R1: While `rst` is high, `lane_rise`, `lane_fall` and `clk_fwd` are all low. After `rst` is released, words captured afterwards are reproduced exactly.
- R2: In fast cycle `p` (0..3) of a word, lane `4*m+j` (group `m` 0..15, lane-in-group `j` 0..3) carries input bit `16*(8*p+j)+m` on `lane_rise` and input bit `16*(8*p+4+j)+m` on `lane_fall`.
- R3: A word captured at slow rising edge T shows its slice 0 on `lane_rise` after the fast rising edge at T+2 fast periods. The matching `lane_fall` half changes half a fast period later, on the rising edge of `clk_fast_n`. Slices 1..3 follow on consecutive fast cycles.
- R4: Consecutive slow words stream with no gap and no repeat. Reading, for each fast cycle `p` and edge `e` (0 rise, 1 fall), lanes `j`=0..3 of every group `m` as serial bit `16*(8*p+4*e+j)+m` rebuilds each input word exactly.
- R5: When `data_oe` is low at a fast rising edge, the `lane_rise` half launched at that edge is all zero. So is the `lane_fall` half launched half a period later.
- R6: `clk_oe` is sampled on the rising edge of `clk_fast_n`. While it is high, `clk_fwd` follows `clk_fast`. While it is low, `clk_fwd` stays low, with no partial pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Word clock; one input word per rising edge |
| clk_fast | input | 1 | Lane clock at four times the word rate, phase aligned |
| clk_fast_n | input | 1 | Inverted copy of `clk_fast` |
| rst | input | 1 | Asynchronous reset, active high |
| clk_oe | input | 1 | Enables the forwarded fast clock |
| data_oe | input | 1 | Enables the data lanes |
| din | input | 512 | Input word, synchronous to `clk_slow` |
| lane_rise | output | 64 | Lane values launched on the `clk_fast` rising edge |
| lane_fall | output | 64 | Lane values launched on the `clk_fast_n` rising edge |
| clk_fwd | output | 1 | Gated forwarded copy of `clk_fast` |

## Verification
The bench rebuilds the serial stream from the lanes and compares it with every input word. Swapping the group stride for the lane stride, or the rise half for the fall half, would scramble the rebuilt word. Single-bit words at index 0, index 64 and index 511 pin the exact lane, edge and fast cycle, so an off-by-one phase restart or a missing cycle of latency would show the bit one slice early or late. Back-to-back words with no idle slow cycle expose a shadow register that is overwritten before its fourth slice leaves. Toggling `data_oe` and `clk_oe`, and applying a reset in the middle of a stream, catch lanes that leak data, a clock that keeps running when disabled, and state that survives reset.

// File: rtl/ddr_lane_gearbox.sv
`timescale 1ns/1ps
module ddr_lane_gearbox #(
  parameter int GROUPS = 16,
  parameter int LPG    = 4,
  parameter int RATIO  = 4,
  localparam int LANES = GROUPS * LPG,
  localparam int DIN_W = 2 * RATIO * LANES,
  localparam int PH_W  = $clog2(RATIO)
) (
  input  logic             clk_slow,
  input  logic             clk_fast,
  input  logic             clk_fast_n,
  input  logic             rst,
  input  logic             clk_oe,
  input  logic             data_oe,
  input  logic [DIN_W-1:0] din,
  output logic [LANES-1:0] lane_rise,
  output logic [LANES-1:0] lane_fall,
  output logic             clk_fwd
);

  logic [DIN_W-1:0] hold;
  logic             tog;
  logic             tog_q;
  logic [DIN_W-1:0] shadow;
  logic [PH_W-1:0]  ph;
  logic [LANES-1:0] fall_stage;
  logic             clk_en;
  logic [LANES-1:0] sl_r [RATIO];
  logic [LANES-1:0] sl_f [RATIO];

  always_ff @(posedge clk_slow or posedge rst)
    if (rst) begin
      hold <= '0;
      tog  <= 1'b0;
    end else begin
      hold <= din;
      tog  <= ~tog;
    end

  for (genvar p = 0; p < RATIO; p++) begin : g_ph
    for (genvar m = 0; m < GROUPS; m++) begin : g_grp
      for (genvar j = 0; j < LPG; j++) begin : g_lane
        assign sl_r[p][LPG*m+j] = shadow[GROUPS*((2*p)*LPG+j)+m];
        assign sl_f[p][LPG*m+j] = shadow[GROUPS*((2*p+1)*LPG+j)+m];
      end
    end
  end

  always_ff @(posedge clk_fast or posedge rst)
    if (rst) begin
      tog_q      <= 1'b0;
      shadow     <= '0;
      ph         <= '0;
      lane_rise  <= '0;
      fall_stage <= '0;
    end else begin
      tog_q <= tog;
      if (tog != tog_q) begin
        shadow <= hold;
        ph     <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
      lane_rise  <= data_oe ? sl_r[ph] : '0;
      fall_stage <= data_oe ? sl_f[ph] : '0;
    end

  always_ff @(posedge clk_fast_n or posedge rst)
    if (rst) begin
      lane_fall <= '0;
      clk_en    <= 1'b0;
    end else begin
      lane_fall <= fall_stage;
      clk_en    <= clk_oe;
    end

  assign clk_fwd = clk_fast & clk_en;

endmodule

// File: rtl/ddr_lane_gearbox_chk.sv
`timescale 1ns/1ps
module ddr_lane_gearbox_chk #(
  parameter int LANES = 64,
  parameter int DIN_W = 512,
  parameter int PH_W  = 2
) (
  input logic             clk_fast,
  input logic             clk_fast_n,
  input logic             rst,
  input logic             clk_oe,
  input logic             data_oe,
  input logic [LANES-1:0] lane_rise,
  input logic [LANES-1:0] lane_fall,
  input logic             clk_fwd,
  input logic [PH_W-1:0]  ph,
  input logic [DIN_W-1:0] shadow
);

  always @(posedge clk_fast)
    if (rst) AST_RESET_QUIET: assert (lane_rise == '0 && lane_fall == '0 && !clk_fwd); // R1

  AST_OE_LOW_ZERO: assert property (@(posedge clk_fast) disable iff (rst)
    !$past(data_oe) |-> (lane_rise == '0 && lane_fall == '0)); // R5

  AST_SLICE0_EDGES: assert property (@(posedge clk_fast) disable iff (rst)
    (ph == PH_W'(1) && $past(data_oe)) |->
      (lane_rise[0] == shadow[0] && lane_rise[LANES-1] == shadow[LANES-1] &&
       lane_fall[0] == shadow[LANES] && lane_fall[LANES-1] == shadow[2*LANES-1])); // R2

  AST_CLK_GATED: assert property (@(posedge clk_fast_n) disable iff (rst)
    !$past(clk_oe) |-> !clk_fwd); // R6

endmodule

bind ddr_lane_gearbox ddr_lane_gearbox_chk #(
  .LANES(LANES), .DIN_W(DIN_W), .PH_W(PH_W)
) u_chk (
  .clk_fast(clk_fast), .clk_fast_n(clk_fast_n), .rst(rst), .clk_oe(clk_oe),
  .data_oe(data_oe), .lane_rise(lane_rise), .lane_fall(lane_fall),
  .clk_fwd(clk_fwd), .ph(ph), .shadow(shadow)
);

// File: tb/tb_ddr_lane_gearbox.sv
`timescale 1ns/1ps
module tb_ddr_lane_gearbox;
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    64'h00000000_00000000, 64'hFFFFFFFF_00000000, 64'h00000001_00000000,
    64'hAAAAAAAA_00000000, 64'h12345678_9E3779B9, 64'hDEADBEEF_0F1E2D3C,
    64'h80000001_7F4A7C15, 64'h55AA33CC_C2B2AE35};

  logic clk_fast = 1'b0, rst = 1'b0, clk_oe = 1'b0, data_oe = 1'b0;
  logic [1:0] div = 2'd0;
  logic [511:0] din = '0;
  logic clk_slow, clk_fast_n, clk_fwd;
  logic [63:0] lane_rise, lane_fall;
  int n_chk = 0, n_bad = 0;
  logic [63:0] rr [4];
  logic [63:0] ff [4];

  always #4 clk_fast = ~clk_fast;
  assign clk_fast_n = ~clk_fast;
  always @(posedge clk_fast) div <= div + 2'd1;
  assign clk_slow = div[1];

  ddr_lane_gearbox dut (.clk_slow(clk_slow), .clk_fast(clk_fast), .clk_fast_n(clk_fast_n),
    .rst(rst), .clk_oe(clk_oe), .data_oe(data_oe), .din(din),
    .lane_rise(lane_rise), .lane_fall(lane_fall), .clk_fwd(clk_fwd));

  function automatic logic [511:0] make_word(input logic [63:0] v);
    logic [511:0] w;
    for (int k = 0; k < 16; k++) w[32*k +: 32] = v[63:32] ^ (v[31:0] * k);
    return w;
  endfunction

  function automatic logic [511:0] rebuild();
    logic [511:0] w;
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 2; e++)
        for (int j = 0; j < 4; j++)
          for (int m = 0; m < 16; m++)
            w[16*(8*p+4*e+j)+m] = e ? ff[p][4*m+j] : rr[p][4*m+j];
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at T0+22 of a word; leaves at T0+46.
  task automatic grab();
    for (int p = 0; p < 4; p++) begin
      rr[p] = lane_rise; ff[p] = lane_fall;
      if (p < 3) #8;
    end
  endtask

  task automatic stream_check(input logic [511:0] w, input string tag);
    logic [511:0] got;
    @(negedge clk_slow); din = w;
    @(posedge clk_slow); #22;
    grab();
    got = rebuild();
    chk(got == w, tag, got, w);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] got;
    #1 rst = 1'b1; clk_oe = 1'b1; data_oe = 1'b1; din = '1;
    repeat (6) @(posedge clk_fast);
    #2;
    chk(lane_rise == '0, "R1 rise in reset", 512'(lane_rise), 512'd0);
    chk(lane_fall == '0, "R1 fall in reset", 512'(lane_fall), 512'd0);
    chk(clk_fwd == 1'b0, "R1 clk in reset", 512'(clk_fwd), 512'd0);
    #3 rst = 1'b0;
    repeat (3) @(posedge clk_slow);

    // Table walk: back-to-back words (R2, R4)
    @(negedge clk_slow); din = make_word(VEC[0]);
    @(posedge clk_slow); #22;
    for (int n = 0; n < NV; n++) begin
      if (n + 1 < NV) din = make_word(VEC[n+1]);
      grab();
      got = rebuild();
      chk(got == make_word(VEC[n]), "R4 R2 stream word", got, make_word(VEC[n]));
      #8;
    end

    // Latency and half-period fall launch (R3)
    @(negedge clk_slow); din = '0;
    @(negedge clk_slow); din = '0; din[0] = 1'b1; din[64] = 1'b1;
    @(posedge clk_slow); #1 din = '0;
    #13; chk(lane_rise[0] == 1'b0, "R3 rise before T+16", 512'(lane_rise), 512'd0);
    #4;  chk(lane_fall[0] == 1'b0, "R3 fall before T+20", 512'(lane_fall), 512'd0);
    #4;  chk(lane_rise == 64'd1, "R3 rise slice0", 512'(lane_rise), 512'd1);
         chk(lane_fall == 64'd1, "R3 fall slice0", 512'(lane_fall), 512'd1);
    #8;  chk(lane_rise == '0 && lane_fall == '0, "R3 slice1 empty", 512'({lane_rise, lane_fall}), 512'd0);

    // Top bit lands on fall half of lane 63 in slice 3 (R2)
    @(negedge clk_slow); din = '0; din[511] = 1'b1;
    @(posedge clk_slow); #1 din = '0;
    #45; chk(lane_fall == 64'h8000_0000_0000_0000, "R2 bit511 fall", 512'(lane_fall), 512'h8000_0000_0000_0000);
         chk(lane_rise == '0, "R2 bit511 rise", 512'(lane_rise), 512'd0);

    // Data enable (R5)
    din = '1; data_oe = 1'b0;
    repeat (3) @(posedge clk_fast);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_fast); #6;
      chk(lane_rise == '0 && lane_fall == '0, "R5 lanes low when disabled", 512'({lane_rise, lane_fall}), 512'd0);
    end
    data_oe = 1'b1;
    repeat (2) @(posedge clk_slow);
    stream_check(make_word(VEC[5]), "R5 restored after enable");

    // Clock enable (R6)
    clk_oe = 1'b1;
    repeat (2) @(posedge clk_fast);
    #2; chk(clk_fwd == 1'b1, "R6 clk high phase", 512'(clk_fwd), 512'd1);
    #4; chk(clk_fwd == 1'b0, "R6 clk low phase", 512'(clk_fwd), 512'd0);
    clk_oe = 1'b0;
    repeat (3) @(posedge clk_fast);
    #2; chk(clk_fwd == 1'b0, "R6 clk held low", 512'(clk_fwd), 512'd0);

    // Reset mid-stream (R1)
    din = '1;
    repeat (2) @(posedge clk_slow);
    #3 rst = 1'b1;
    #1; chk(lane_rise == '0 && lane_fall == '0, "R1 mid-run reset clears", 512'({lane_rise, lane_fall}), 512'd0);
    repeat (4) @(posedge clk_fast);
    #3 rst = 1'b0;
    repeat (2) @(posedge clk_slow);
    stream_check(make_word(VEC[7]), "R1 stream after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule